// File: doc/BRIEF.md
# Iterative Integer Divider

This block divides a two-word or one-word integer by a single-word divisor, one quotient bit per clock. The caller presents the operands and the mode (signed or unsigned; long dividend made of a high and a low word, or short dividend made of the low word only) and raises `start` for one cycle. The block takes the magnitudes of the operands, runs a restoring shift-subtract loop for exactly as many cycles as the divisor has bits, and then applies the sign rules. It raises `done` for one cycle with the quotient, the remainder and two flags. Long and short operations take the same number of iterations, so latency does not depend on the mode.

Signed results truncate toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend. A zero divisor is reported on `div_zero`. A quotient that cannot be represented in one word is reported on `ovf`. When either flag is set, the quotient and remainder values carry no meaning. Operand selection and result write-back belong to the surrounding datapath.

Top module: `iter_divider`

## Requirements
- R1: Unsigned long mode (`is_signed`=0, `is_long`=1) divides the unsigned 32-bit value {`dvd_hi`,`dvd_lo`} by the unsigned `dvs`. When neither flag is set, it returns the exact 16-bit quotient and remainder.
- R2: Signed long mode (`is_signed`=1, `is_long`=1) treats {`dvd_hi`,`dvd_lo`} and `dvs` as two's complement. The quotient truncates toward zero, and the remainder is zero or has the sign of the dividend.
- R3: Short mode (`is_long`=0) ignores `dvd_hi`. The dividend is `dvd_lo`, sign-extended when `is_signed`=1 and zero-extended otherwise.
- R4: `done` is high for exactly one cycle. It rises after the 17th rising edge that follows the edge that accepted `start`, in every mode.
- R5: `busy` is high from the edge that accepts `start` until `done` rises. It is low in the cycle where `done` is high.
- R6: A `start` is accepted only while `busy` is low. A `start` raised while busy is ignored: it does not change the results or the timing of the running operation.
- R7: `div_zero` is 1 at `done` exactly when the divisor was zero, and `ovf` is 0 in that case.
- R8: For a non-zero divisor, `ovf` is 1 at `done` exactly when the true quotient lies outside 0..65535 (unsigned) or outside -32768..32767 (signed).
- R9: While reset is asserted, `busy`, `done`, `div_zero`, `ovf`, `quot` and `rmd` are all 0.
- R10: `quot`, `rmd`, `div_zero` and `ovf` keep their values in every cycle where `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin an operation (taken only when not busy) |
| is_signed | input | 1 | 1 = two's complement operands |
| is_long | input | 1 | 1 = dividend is {dvd_hi, dvd_lo}; 0 = dvd_lo alone |
| dvd_hi | input | 16 | Dividend high word |
| dvd_lo | input | 16 | Dividend low word |
| dvs | input | 16 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, results valid |
| quot | output | 16 | Quotient |
| rmd | output | 16 | Remainder |
| div_zero | output | 1 | Divisor was zero |
| ovf | output | 1 | Quotient did not fit in one word |

## Verification
The bench targets the signed extremes. Tests include -65536/2, which gives exactly -32768 and must not flag. They include 65536/2 and -2^31/-1, which must flag, and a design that checked only the unsigned magnitude would miss these. A negative dividend with a positive divisor, and the reverse, catch a remainder that takes the divisor's sign or a quotient that rounds toward minus infinity. Short-mode operations run with a non-zero high word. This exposes a design that leaks `dvd_hi` into the result or zero-extends a negative low word. A start pulse raised mid-operation, and a new start raised in the very cycle of `done`, expose a design that restarts, drops a request or shifts the latency.

// File: rtl/div_pkg.sv
// Shared types for the iterative divider.
package div_pkg;
    // Controller states: waiting, iterating, applying signs
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } div_state_e;
endpackage

// File: rtl/div_operand_prep.sv
// Conditions the raw operands for an unsigned shift-subtract loop.
// Extends a short dividend, takes magnitudes in signed mode, records the
// result signs and predicts an unsigned quotient overflow from the high word.
// Assumes: purely combinational; operands are held stable while start is seen.
module div_operand_prep #(
    parameter int DW = 16
) (
    input  logic          is_signed,
    input  logic          is_long,
    input  logic [DW-1:0] dvd_hi,
    input  logic [DW-1:0] dvd_lo,
    input  logic [DW-1:0] dvs,
    output logic [DW-1:0] rem_init,
    output logic [DW-1:0] quo_init,
    output logic [DW-1:0] dvs_mag,
    output logic          neg_quot,
    output logic          neg_rem,
    output logic          zero_dvs,
    output logic          pre_ovf
);
    localparam int FW = 2 * DW;

    logic [DW-1:0] hi_ext;
    logic [FW-1:0] full;
    logic [FW-1:0] mag;
    logic          sd;
    logic          sv;

    // Build the full-width dividend and the operand magnitudes
    always_comb begin
        hi_ext   = is_long ? dvd_hi : {DW{is_signed & dvd_lo[DW-1]}};
        full     = {hi_ext, dvd_lo};
        sd       = is_signed & hi_ext[DW-1];
        sv       = is_signed & dvs[DW-1];
        mag      = sd ? (~full + 1'b1) : full;
        dvs_mag  = sv ? (~dvs + 1'b1) : dvs;
        rem_init = mag[FW-1:DW];
        quo_init = mag[DW-1:0];
        neg_quot = sd ^ sv;
        neg_rem  = sd;
        zero_dvs = (dvs == '0);
        pre_ovf  = (mag[FW-1:DW] >= dvs_mag);
    end
endmodule

// File: rtl/div_step.sv
// One restoring division step: shift one dividend bit into the partial
// remainder, subtract the divisor if it fits and record the quotient bit.
// Assumes: r_in < d on entry, so the new remainder fits DW bits.
module div_step #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] r_in,
    input  logic [DW-1:0] q_in,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] r_out,
    output logic [DW-1:0] q_out
);
    logic [DW:0] trial;
    logic [DW:0] diff;
    logic        fits;

    // Compare-and-subtract for a single quotient bit
    always_comb begin
        trial = {r_in, q_in[DW-1]};
        diff  = trial - {1'b0, d};
        fits  = (trial >= {1'b0, d});
        r_out = fits ? diff[DW-1:0] : trial[DW-1:0];
        q_out = {q_in[DW-2:0], fits};
    end
endmodule

// File: rtl/div_result_fix.sv
// Applies the sign rules to the unsigned quotient and remainder and
// decides the overflow flag. Assumes: purely combinational.
module div_result_fix #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] q_mag,
    input  logic [DW-1:0] r_mag,
    input  logic          sgn,
    input  logic          neg_quot,
    input  logic          neg_rem,
    input  logic          zero_dvs,
    input  logic          pre_ovf,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rmd,
    output logic          ovf
);
    localparam logic [DW-1:0] MOST_NEG = {1'b1, {(DW-1){1'b0}}};

    logic sgn_ovf;

    // Negate where required and test the signed range
    always_comb begin
        quot    = neg_quot ? (~q_mag + 1'b1) : q_mag;
        rmd     = neg_rem  ? (~r_mag + 1'b1) : r_mag;
        sgn_ovf = sgn & q_mag[DW-1] & ~(neg_quot & (q_mag == MOST_NEG));
        ovf     = ~zero_dvs & (pre_ovf | sgn_ovf);
    end
endmodule

// File: rtl/iter_divider.sv
// Iterative signed/unsigned divider, long (two-word) or short dividend over a
// one-word divisor. One quotient bit per cycle for DW cycles, then one cycle
// of sign correction; done pulses for a cycle and results hold until the next.
// Assumes: synchronous active-low reset; start ignored while busy.
module iter_divider #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          is_signed,
    input  logic          is_long,
    input  logic [DW-1:0] dvd_hi,
    input  logic [DW-1:0] dvd_lo,
    input  logic [DW-1:0] dvs,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rmd,
    output logic          div_zero,
    output logic          ovf
);
    import div_pkg::*;

    localparam int            CW   = (DW > 2) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    div_state_e    state;
    logic [CW-1:0] cnt;
    logic [DW-1:0] r_q, q_q, d_q;
    logic          sgn_q, negq_q, negr_q, zero_q, povf_q;

    logic [DW-1:0] p_rem, p_quo, p_dmag;
    logic          p_negq, p_negr, p_zero, p_povf;
    logic [DW-1:0] s_rem, s_quo;
    logic [DW-1:0] f_quot, f_rmd;
    logic          f_ovf;

    div_operand_prep #(.DW(DW)) u_prep (
        .is_signed (is_signed),
        .is_long   (is_long),
        .dvd_hi    (dvd_hi),
        .dvd_lo    (dvd_lo),
        .dvs       (dvs),
        .rem_init  (p_rem),
        .quo_init  (p_quo),
        .dvs_mag   (p_dmag),
        .neg_quot  (p_negq),
        .neg_rem   (p_negr),
        .zero_dvs  (p_zero),
        .pre_ovf   (p_povf)
    );

    div_step #(.DW(DW)) u_step (
        .r_in  (r_q),
        .q_in  (q_q),
        .d     (d_q),
        .r_out (s_rem),
        .q_out (s_quo)
    );

    div_result_fix #(.DW(DW)) u_fix (
        .q_mag    (q_q),
        .r_mag    (r_q),
        .sgn      (sgn_q),
        .neg_quot (negq_q),
        .neg_rem  (negr_q),
        .zero_dvs (zero_q),
        .pre_ovf  (povf_q),
        .quot     (f_quot),
        .rmd      (f_rmd),
        .ovf      (f_ovf)
    );

    // Busy covers the iteration and sign-correction states
    assign busy = (state != ST_IDLE);

    // Sequencer, working registers and held results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            r_q      <= '0;
            q_q      <= '0;
            d_q      <= '0;
            sgn_q    <= 1'b0;
            negq_q   <= 1'b0;
            negr_q   <= 1'b0;
            zero_q   <= 1'b0;
            povf_q   <= 1'b0;
            done     <= 1'b0;
            quot     <= '0;
            rmd      <= '0;
            div_zero <= 1'b0;
            ovf      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        r_q    <= p_rem;
                        q_q    <= p_quo;
                        d_q    <= p_dmag;
                        sgn_q  <= is_signed;
                        negq_q <= p_negq;
                        negr_q <= p_negr;
                        zero_q <= p_zero;
                        povf_q <= p_povf;
                        cnt    <= '0;
                        state  <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    r_q <= s_rem;
                    q_q <= s_quo;
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST) begin
                        state <= ST_FIN;
                    end
                end
                ST_FIN: begin
                    quot     <= f_quot;
                    rmd      <= f_rmd;
                    div_zero <= zero_q;
                    ovf      <= f_ovf;
                    done     <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/iter_divider_chk.sv
// Protocol checker for iter_divider: tracks accepted starts with its own
// counter and checks timing, flag and hold properties at the ports.
module iter_divider_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] dvs,
    input logic          busy,
    input logic          done,
    input logic [DW-1:0] quot,
    input logic [DW-1:0] rmd,
    input logic          div_zero,
    input logic          ovf
);
    localparam int           LAT = DW + 2;
    localparam int           TW  = $clog2(LAT + 1);
    localparam logic [TW-1:0] LATV = TW'(LAT);

    logic [TW-1:0] tcnt;
    logic          zlat;

    // Count edges since the accepted start and latch the zero-divisor fact
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tcnt <= '0;
            zlat <= 1'b0;
        end else if (start && !busy) begin
            tcnt <= TW'(1);
            zlat <= (dvs == '0);
        end else if (tcnt == LATV) begin
            tcnt <= '0;
        end else if (tcnt != '0) begin
            tcnt <= tcnt + 1'b1;
        end
    end

    // R4
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tcnt == LATV));

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((tcnt != '0) && (tcnt != LATV)) |-> busy);

    // R5
    idle_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (div_zero == zlat));

    // R7
    zero_no_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_zero) |-> !ovf);

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(quot) && $stable(rmd) && $stable(div_zero) && $stable(ovf)));
endmodule

bind iter_divider iter_divider_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .dvs      (dvs),
    .busy     (busy),
    .done     (done),
    .quot     (quot),
    .rmd      (rmd),
    .div_zero (div_zero),
    .ovf      (ovf)
);

// File: tb/tb_iter_divider.sv
`timescale 1ns/1ps
module tb_iter_divider;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_signed = 1'b0;
    logic        is_long = 1'b0;
    logic [15:0] dvd_hi = '0;
    logic [15:0] dvd_lo = '0;
    logic [15:0] dvs = '0;
    logic        busy, done, div_zero, ovf;
    logic [15:0] quot, rmd;

    always #2.5 clk = ~clk;

    iter_divider dut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
        .is_long(is_long), .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .dvs(dvs),
        .busy(busy), .done(done), .quot(quot), .rmd(rmd),
        .div_zero(div_zero), .ovf(ovf)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    bit model_on = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state: m = edges since acceptance (0 = idle)
    int     m = 0;
    longint eq, er;
    bit     ez, eo;
    string  etag;
    logic [15:0] pq, pr;
    logic   pz, po;
    bit     hv = 1'b0;

    // Model update on each rising edge, from the requirements only
    always @(posedge clk) begin
        longint n, d;
        if (!rst_n) begin
            m = 0;
        end else if ((m == 0 || m == 18) && start) begin
            m = 1;
            if (is_signed) begin
                n = is_long ? longint'($signed({dvd_hi, dvd_lo})) : longint'($signed(dvd_lo));
                d = longint'($signed(dvs));
            end else begin
                n = is_long ? longint'({dvd_hi, dvd_lo}) : longint'(dvd_lo);
                d = longint'(dvs);
            end
            etag = !is_long ? "R3" : (is_signed ? "R2" : "R1");
            ez = (d == 0);
            if (ez) begin
                eo = 1'b0; eq = 0; er = 0;
            end else begin
                eq = n / d;
                er = n % d;
                eo = is_signed ? (eq > 32767 || eq < -32768) : (eq > 65535);
            end
        end else if (m == 18) begin
            m = 0;
        end else if (m != 0) begin
            m = m + 1;
        end
    end

    // Compare on every falling edge
    always @(negedge clk) begin
        if (rst_n && model_on) begin
            chk(busy == (m >= 1 && m <= 17), "R5", "busy", busy, (m >= 1 && m <= 17));
            chk(done == (m == 18), "R4", "done", done, (m == 18));
            if (m == 18) begin
                chk(div_zero == ez, "R7", "div_zero", div_zero, ez);
                chk(ovf == eo, "R8", "ovf", ovf, eo);
                if (!ez && !eo) begin
                    chk(quot == eq[15:0], etag, "quot", quot, eq[15:0]);
                    chk(rmd == er[15:0], etag, "rmd", rmd, er[15:0]);
                end
            end else if (hv) begin
                chk(quot == pq && rmd == pr && div_zero == pz && ovf == po,
                    "R10", "held results", {quot, rmd}, {pq, pr});
            end
            pq = quot; pr = rmd; pz = div_zero; po = ovf; hv = 1'b1;
        end
    end

    // Drive an operation from the current time (a falling edge)
    task automatic issue(input bit s, input bit l, input logic [15:0] h,
                         input logic [15:0] lo, input logic [15:0] dv);
        is_signed = s; is_long = l; dvd_hi = h; dvd_lo = lo; dvs = dv;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (17) @(negedge clk);
    endtask

    task automatic op(input bit s, input bit l, input logic [15:0] h,
                      input logic [15:0] lo, input logic [15:0] dv);
        @(negedge clk);
        issue(s, l, h, lo, dv);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(!busy && !done && !div_zero && !ovf && quot == 0 && rmd == 0,
            "R9", "reset outputs", {busy, done, div_zero, ovf, quot, rmd}, 0);
        rst_n = 1'b1;
        model_on = 1'b1;

        // R1: unsigned long
        op(0, 1, 16'h0001, 16'h86A0, 16'd7);
        op(0, 1, 16'hFFFE, 16'hFFFF, 16'hFFFF);
        op(0, 1, 16'h0000, 16'h0005, 16'd9);
        // R8: unsigned quotient too wide
        op(0, 1, 16'h0001, 16'h0000, 16'd1);
        // R2: signed long, mixed signs
        op(1, 1, 16'hFFFE, 16'h7960, 16'd7);
        op(1, 1, 16'h0001, 16'h86A0, 16'hFFF9);
        op(1, 1, 16'hFFFF, 16'h0000, 16'd2);   // -65536/2 = -32768, fits
        op(1, 1, 16'h0001, 16'h0000, 16'd2);   // R8: 32768 overflows
        op(1, 1, 16'h8000, 16'h0000, 16'hFFFF); // R8: -2^31/-1
        // R3: short modes with garbage in the high word
        op(1, 0, 16'h1234, 16'hFFF9, 16'hFFFE);
        op(0, 0, 16'hBEEF, 16'hFFF9, 16'd2);
        op(1, 0, 16'hA5A5, 16'h8000, 16'hFFFF); // R8: short signed overflow
        // R7: zero divisor
        op(0, 1, 16'h0012, 16'h3456, 16'd0);
        op(1, 0, 16'h0000, 16'h0042, 16'd0);

        // R6: start raised mid-operation is ignored
        @(negedge clk);
        is_signed = 0; is_long = 1; dvd_hi = 16'h0000; dvd_lo = 16'd1000; dvs = 16'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (4) @(negedge clk);
        dvd_lo = 16'd50; dvs = 16'd0; start = 1'b1;  // R6 ignored request
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        chk(done && quot == 16'd333 && rmd == 16'd1 && !div_zero, "R6",
            "result after ignored start", {quot, rmd}, {16'd333, 16'd1});

        // R4: new start in the done cycle, back to back
        issue(1, 1, 16'hFFFF, 16'hFFF9, 16'd2);
        issue(0, 0, 16'h0000, 16'd100, 16'd10);

        // Mixed random operations
        for (int i = 0; i < 120; i++) begin
            op($urandom_range(0, 1), $urandom_range(0, 1),
               16'($urandom & 32'h00FF), 16'($urandom), 16'($urandom));
        end

        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule